// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central hazard controller of a single-wide, out-of-order-issue pipeline built from fetch, dispatch, issue, execute and writeback stages. Each cycle it can take one decoded instruction, described by a class, an optional destination register and two source registers. It holds one status entry per functional unit: busy, destination, sources, and the tag of the unit that will produce each source. It also holds one producer tag per architectural register. From these tables it decides when dispatch must stall, when a waiting unit may read its operands and start, and when a finished unit may write its result.

Five units are provided by default: an ALU, a load unit, a store unit and two floating-point units. Operands pass only through the register file, so there is no bypass path. The execution datapaths are not part of the block. Each unit is modelled by an internal latency counter, and the counter's expiry stands for the unit's done signal. Dispatch stays in program order. Issue and writeback are out of order.

Top module: `hazard_scoreboard`

## Requirements
- R1: After synchronous reset every unit is free and every register tag is zero. With no input offered, `in_ready` is 1 and `iss_vec`, `wb_vec` and `disp_tag` are all 0.
- R2: Unit tags are 1 for the ALU, 2 for the load unit, 3 for the store unit, and 4 upward for the FP units. Tag 0 means "value ready". In a cycle where `in_valid` and `in_ready` are both high, `disp_tag` carries the allocated unit's tag. In any other cycle it is 0. Bit k of `iss_vec` and `wb_vec` belongs to tag k+1.
- R3: Dispatch stalls while no unit of the requested class is free. A unit that completes in a cycle counts as free in that same cycle, so it can be reallocated at once.
- R4: Dispatch of a register-writing instruction stalls while its destination has a pending producer (WAW). The stall releases in the cycle in which that producer writes back.
- R5: Dispatch is in order. While the offered instruction is stalled, `in_ready` stays low and no younger instruction is accepted.
- R6: A waiting unit issues only when both source tags are zero, or when they name the unit writing back in that same cycle (RAW).
- R7: A unit waiting on a RAW hazard does not delay issue by any other unit.
- R8: A finished register-writing unit holds its writeback while another unit that has not yet issued reads that destination with a zero source tag (WAR).
- R9: At most one unit completes per cycle. Among eligible units the lowest tag wins, and the others wait.
- R10: An FP instruction is placed in the lowest-numbered free FP unit.
- R11: Issue comes no earlier than the cycle after dispatch. Execution lasts the unit's latency (ALU 1, load 1, store 1, FP 3 by default). Completion is eligible in the following cycle. A unit never issues and completes in the same cycle.
- R12: Class codes are 0 ALU, 1 load, 2 store, 3 FP. A destination is recorded only when `in_wr` is 1. A unit without a destination completes with `wb_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded instruction is offered |
| in_cls | input | 2 | Instruction class (R12 codes) |
| in_wr | input | 1 | Instruction writes a destination register |
| in_dst | input | log2(NREG) | Destination register index |
| in_src1 | input | log2(NREG) | First source register index |
| in_src2 | input | log2(NREG) | Second source register index |
| in_ready | output | 1 | Offered instruction is accepted this cycle if valid |
| disp_tag | output | log2(NFP+4) | Tag of the unit allocated this cycle, 0 if none |
| iss_vec | output | NFP+3 | Units that read operands and start this cycle |
| wb_vec | output | NFP+3 | Unit completing this cycle (one-hot or zero) |
| wb_we | output | 1 | Completion writes the register file |
| wb_reg | output | log2(NREG) | Register written on completion |

## Verification
The main stimulus is two iterations of a load, multiply, store and add-to-index loop. Its dispatch, issue and completion cycles are compared against a hand-derived schedule. That schedule can only come out right if the WAW stall, the WAR writeback hold, the structural stall, same-cycle RAW wake-up and free-then-allocate all behave as required. A second pattern uses independent registers. Two FP operations and an ALU operation finish in colliding cycles while a third FP operation waits for a unit, which separates the completion priority and the FP unit choice from any dependency effect. A reset pattern confirms the idle outputs.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [1:0] {
    CLS_ALU = 2'd0,
    CLS_LD  = 2'd1,
    CLS_ST  = 2'd2,
    CLS_FP  = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_EXEC = 2'd1,
    PH_DONE = 2'd2
  } phase_e;
endpackage

// File: rtl/hsb_pick.sv
// Lowest-index request wins; tag is index+1, zero when nothing requests.
module hsb_pick #(
  parameter int N  = 5,
  parameter int TW = $clog2(N + 1)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [TW-1:0] tag
);
  always_comb begin
    gnt = '0;
    tag = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        tag    = TW'(i + 1);
      end
    end
  end
endmodule

// File: rtl/hsb_rtab.sv
// Producer tag per architectural register; a new producer overrides a clear.
module hsb_rtab #(
  parameter int NREG = 16,
  parameter int TW   = 3,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [RW-1:0] set_idx,
  input  logic [TW-1:0] set_tag,
  input  logic          clr_en,
  input  logic [RW-1:0] clr_idx,
  input  logic [TW-1:0] clr_tag,
  input  logic [RW-1:0] rd_a,
  input  logic [RW-1:0] rd_b,
  input  logic [RW-1:0] rd_c,
  output logic [TW-1:0] tag_a,
  output logic [TW-1:0] tag_b,
  output logic [TW-1:0] tag_c
);
  logic [TW-1:0] tab [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREG; k++) tab[k] <= '0;
    end else begin
      if (clr_en && tab[clr_idx] == clr_tag) tab[clr_idx] <= '0;
      if (set_en) tab[set_idx] <= set_tag;
    end
  end

  assign tag_a = tab[rd_a];
  assign tag_b = tab[rd_b];
  assign tag_c = tab[rd_c];
endmodule

// File: rtl/hsb_unit.sv
// One functional-unit status entry with its latency counter.
module hsb_unit
  import hsb_pkg::*;
#(
  parameter int RW  = 4,
  parameter int TW  = 3,
  parameter int LAT = 1,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc,
  input  logic          a_wr,
  input  logic [RW-1:0] a_dst,
  input  logic [RW-1:0] a_s1,
  input  logic [RW-1:0] a_s2,
  input  logic [TW-1:0] a_t1,
  input  logic [TW-1:0] a_t2,
  input  logic          wb_fire,
  input  logic [TW-1:0] wb_tag,
  input  logic          grant,
  output logic          busy,
  output logic          waiting,
  output logic          done,
  output logic          issue,
  output logic          wr,
  output logic [RW-1:0] dst,
  output logic [RW-1:0] s1,
  output logic [RW-1:0] s2,
  output logic          t1z,
  output logic          t2z
);
  phase_e        ph;
  logic [CW-1:0] cnt;
  logic [TW-1:0] t1, t2;
  logic          t1_ok, t2_ok;

  assign t1_ok   = (t1 == '0) || (wb_fire && t1 == wb_tag);
  assign t2_ok   = (t2 == '0) || (wb_fire && t2 == wb_tag);
  assign waiting = busy && ph == PH_WAIT;
  assign done    = busy && ph == PH_DONE;
  assign issue   = waiting && t1_ok && t2_ok;
  assign t1z     = (t1 == '0);
  assign t2z     = (t2 == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      ph   <= PH_WAIT;
      cnt  <= '0;
      wr   <= 1'b0;
      dst  <= '0;
      s1   <= '0;
      s2   <= '0;
      t1   <= '0;
      t2   <= '0;
    end else if (alloc) begin
      busy <= 1'b1;
      ph   <= PH_WAIT;
      wr   <= a_wr;
      dst  <= a_dst;
      s1   <= a_s1;
      s2   <= a_s2;
      t1   <= a_t1;
      t2   <= a_t2;
    end else if (busy) begin
      if (wb_fire && t1 == wb_tag) t1 <= '0;
      if (wb_fire && t2 == wb_tag) t2 <= '0;
      case (ph)
        PH_WAIT: if (issue) begin
          ph  <= PH_EXEC;
          cnt <= CW'(LAT - 1);
        end
        PH_EXEC: if (cnt == '0) ph <= PH_DONE;
                 else cnt <= cnt - 1'b1;
        default: if (grant) begin
          busy <= 1'b0;
          ph   <= PH_WAIT;
        end
      endcase
    end
  end
endmodule

// File: rtl/hazard_scoreboard.sv
module hazard_scoreboard
  import hsb_pkg::*;
#(
  parameter int NREG    = 16,
  parameter int NFP     = 2,
  parameter int LAT_ALU = 1,
  parameter int LAT_MEM = 1,
  parameter int LAT_FP  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [1:0]              in_cls,
  input  logic                    in_wr,
  input  logic [$clog2(NREG)-1:0] in_dst,
  input  logic [$clog2(NREG)-1:0] in_src1,
  input  logic [$clog2(NREG)-1:0] in_src2,
  output logic                    in_ready,
  output logic [$clog2(NFP+4)-1:0] disp_tag,
  output logic [NFP+2:0]          iss_vec,
  output logic [NFP+2:0]          wb_vec,
  output logic                    wb_we,
  output logic [$clog2(NREG)-1:0] wb_reg
);
  localparam int RW = $clog2(NREG);
  localparam int NU = NFP + 3;
  localparam int TW = $clog2(NU + 1);

  logic [NU-1:0] busy_vec, u_wait, u_done, u_issue, u_wr, u_t1z, u_t2z;
  logic [NU-1:0] war, wb_req, cand, alloc_vec, cand_gnt;
  logic [RW-1:0] u_dst [NU];
  logic [RW-1:0] u_s1  [NU];
  logic [RW-1:0] u_s2  [NU];
  logic [TW-1:0] wb_tag, cand_tag, rt_d, rt_s1, rt_s2, e_d, e_s1, e_s2;
  logic          wb_fire, waw;

  // WAR: an unissued reader still expects the old register contents.
  always_comb begin
    for (int i = 0; i < NU; i++) begin
      war[i] = 1'b0;
      for (int j = 0; j < NU; j++) begin
        if (j != i && u_wait[j] &&
            ((u_s1[j] == u_dst[i] && u_t1z[j]) || (u_s2[j] == u_dst[i] && u_t2z[j])))
          war[i] = u_wr[i];
      end
    end
  end

  assign wb_req = u_done & ~war;

  hsb_pick #(.N(NU), .TW(TW)) i_wb_pick (.req(wb_req), .gnt(wb_vec), .tag(wb_tag));

  assign wb_fire = |wb_vec;

  always_comb begin
    wb_we  = 1'b0;
    wb_reg = '0;
    for (int i = 0; i < NU; i++) begin
      if (wb_vec[i]) begin
        wb_we  = u_wr[i];
        wb_reg = u_dst[i];
      end
    end
  end

  // Class match against units that are idle or finishing this cycle.
  always_comb begin
    for (int i = 0; i < NU; i++) begin
      logic ok;
      case (cls_e'(in_cls))
        CLS_ALU: ok = (i == 0);
        CLS_LD:  ok = (i == 1);
        CLS_ST:  ok = (i == 2);
        default: ok = (i >= 3);
      endcase
      cand[i] = ok && (!busy_vec[i] || wb_vec[i]);
    end
  end

  hsb_pick #(.N(NU), .TW(TW)) i_ds_pick (.req(cand), .gnt(cand_gnt), .tag(cand_tag));

  hsb_rtab #(.NREG(NREG), .TW(TW)) i_rtab (
    .clk(clk), .rst(rst),
    .set_en(in_valid && in_ready && in_wr), .set_idx(in_dst), .set_tag(cand_tag),
    .clr_en(wb_we), .clr_idx(wb_reg), .clr_tag(wb_tag),
    .rd_a(in_dst), .rd_b(in_src1), .rd_c(in_src2),
    .tag_a(rt_d), .tag_b(rt_s1), .tag_c(rt_s2)
  );

  // A producer finishing this cycle counts as already done.
  assign e_d  = (wb_fire && rt_d  == wb_tag) ? '0 : rt_d;
  assign e_s1 = (wb_fire && rt_s1 == wb_tag) ? '0 : rt_s1;
  assign e_s2 = (wb_fire && rt_s2 == wb_tag) ? '0 : rt_s2;
  assign waw  = in_wr && e_d != '0;

  assign in_ready  = (|cand) && !waw;
  assign alloc_vec = (in_valid && in_ready) ? cand_gnt : '0;
  assign disp_tag  = (in_valid && in_ready) ? cand_tag : '0;
  assign iss_vec   = u_issue;

  for (genvar g = 0; g < NU; g++) begin : g_unit
    localparam int L = (g == 0) ? LAT_ALU : (g < 3) ? LAT_MEM : LAT_FP;
    hsb_unit #(.RW(RW), .TW(TW), .LAT(L)) i_unit (
      .clk(clk), .rst(rst),
      .alloc(alloc_vec[g]), .a_wr(in_wr), .a_dst(in_dst),
      .a_s1(in_src1), .a_s2(in_src2), .a_t1(e_s1), .a_t2(e_s2),
      .wb_fire(wb_fire), .wb_tag(wb_tag), .grant(wb_vec[g]),
      .busy(busy_vec[g]), .waiting(u_wait[g]), .done(u_done[g]), .issue(u_issue[g]),
      .wr(u_wr[g]), .dst(u_dst[g]), .s1(u_s1[g]), .s2(u_s2[g]),
      .t1z(u_t1z[g]), .t2z(u_t2z[g])
    );
  end
endmodule

// File: rtl/hazard_scoreboard_chk.sv
module hazard_scoreboard_chk #(
  parameter int NFP = 2,
  localparam int NU = NFP + 3,
  localparam int TW = $clog2(NU + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [TW-1:0] disp_tag,
  input logic [NU-1:0] iss_vec,
  input logic [NU-1:0] wb_vec,
  input logic [NU-1:0] busy_vec,
  input logic [NU-1:0] alloc_vec
);
  a_r9_single_write: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wb_vec));

  a_r2_tag_on_accept: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |-> disp_tag != '0);

  a_r3_alloc_on_free: assert property (@(posedge clk) disable iff (rst)
    (alloc_vec & busy_vec & ~wb_vec) == '0);

  a_r11_iss_wb_apart: assert property (@(posedge clk) disable iff (rst)
    (iss_vec & wb_vec) == '0);

  a_r11_wb_frees: assert property (@(posedge clk) disable iff (rst)
    |wb_vec |=> (busy_vec & $past(wb_vec) & ~$past(alloc_vec)) == '0);
endmodule

bind hazard_scoreboard hazard_scoreboard_chk #(.NFP(NFP)) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .disp_tag(disp_tag), .iss_vec(iss_vec), .wb_vec(wb_vec),
  .busy_vec(busy_vec), .alloc_vec(alloc_vec)
);

// File: tb/test_hazard_scoreboard.sv
`timescale 1ns/1ps
module test_hazard_scoreboard;
  localparam int NU = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [1:0] in_cls = 2'd0;
  logic       in_wr = 1'b0;
  logic [3:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic       in_ready;
  logic [2:0] disp_tag;
  logic [4:0] iss_vec, wb_vec;
  logic       wb_we;
  logic [3:0] wb_reg;

  hazard_scoreboard i_hazard_scoreboard (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls), .in_wr(in_wr),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .in_ready(in_ready),
    .disp_tag(disp_tag), .iss_vec(iss_vec), .wb_vec(wb_vec), .wb_we(wb_we), .wb_reg(wb_reg)
  );

  always #2.5 clk = ~clk;

  int cyc = 0, base = 0, cur = 0, total = 0, bad = 0;
  int ds_c[8], is_c[8], wb_c[8], tg[8], we_c[8], owner[8];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc > 4000) begin
      total++; bad++;
      $display("FAIL R11 watchdog actual=%0d expected<=4000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Record the cycle (relative to scenario start) of each stage per instruction.
  always @(negedge clk) begin
    if (!rst) begin
      for (int u = 0; u < NU; u++) begin
        if (wb_vec[u]) begin
          wb_c[owner[u+1]] = cyc - base + 1;
          we_c[owner[u+1]] = int'(wb_we);
        end
        if (iss_vec[u]) is_c[owner[u+1]] = cyc - base + 1;
      end
      if (in_valid && in_ready) begin
        ds_c[cur] = cyc - base + 1;
        tg[cur] = int'(disp_tag);
        owner[disp_tag] = cur;
      end
    end
  end

  task automatic chk(input string r, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    for (int k = 0; k < 8; k++) begin
      ds_c[k] = -1; is_c[k] = -1; wb_c[k] = -1; tg[k] = -1; we_c[k] = -1; owner[k] = 0;
    end
  endtask

  task automatic send(input int k, input logic [1:0] c, input logic w,
                      input logic [3:0] d, input logic [3:0] a, input logic [3:0] b);
    logic acc;
    cur = k; in_cls = c; in_wr = w; in_dst = d; in_src1 = a; in_src2 = b;
    in_valid = 1'b1;
    do begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk);
      #1;
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1", "in_ready idle", int'(in_ready), 1);
    chk("R1", "iss_vec idle", int'(iss_vec), 0);
    chk("R1", "wb_vec idle", int'(wb_vec), 0);
    chk("R2", "disp_tag without valid", int'(disp_tag), 0);
  endtask

  // Two passes of load f0 / mul f4=f0*f2 / store f4 / add r1; regs f0=0 f2=2 f4=4 r1=8.
  task automatic t_loop();
    do_reset();
    @(posedge clk); #1 base = cyc;
    send(0, 2'd1, 1'b1, 4'd0, 4'd8, 4'd8);
    send(1, 2'd3, 1'b1, 4'd4, 4'd0, 4'd2);
    send(2, 2'd2, 1'b0, 4'd0, 4'd4, 4'd8);
    send(3, 2'd0, 1'b1, 4'd8, 4'd8, 4'd8);
    send(4, 2'd1, 1'b1, 4'd0, 4'd8, 4'd8);
    send(5, 2'd3, 1'b1, 4'd4, 4'd0, 4'd2);
    send(6, 2'd2, 1'b0, 4'd0, 4'd4, 4'd8);
    repeat (14) @(posedge clk);
    #1;
    chk("R11", "ld1 ds", ds_c[0], 1);  chk("R11", "ld1 is", is_c[0], 2);  chk("R11", "ld1 wb", wb_c[0], 4);
    chk("R2",  "ld1 tag", tg[0], 2);
    chk("R11", "mul1 ds", ds_c[1], 2); chk("R6",  "mul1 is same-cycle RAW", is_c[1], 4);
    chk("R11", "mul1 wb", wb_c[1], 8); chk("R10", "mul1 tag", tg[1], 4);
    chk("R11", "st1 ds", ds_c[2], 3);  chk("R6",  "st1 is", is_c[2], 8);
    chk("R11", "st1 wb", wb_c[2], 10); chk("R12", "st1 no write", we_c[2], 0);
    chk("R2",  "st1 tag", tg[2], 3);
    chk("R7",  "add ds", ds_c[3], 4);  chk("R7",  "add is past waiting store", is_c[3], 5);
    chk("R8",  "add wb held by WAR", wb_c[3], 9); chk("R2", "add tag", tg[3], 1);
    chk("R3",  "ld2 ds on freed unit", ds_c[4], 5); chk("R6", "ld2 is", is_c[4], 9);
    chk("R11", "ld2 wb", wb_c[4], 11);
    chk("R4",  "mul2 ds after WAW", ds_c[5], 8); chk("R10", "mul2 lowest free FP", tg[5], 4);
    chk("R6",  "mul2 is", is_c[5], 11); chk("R11", "mul2 wb", wb_c[5], 15);
    chk("R5",  "st2 ds after structural stall", ds_c[6], 10);
    chk("R6",  "st2 is", is_c[6], 15); chk("R11", "st2 wb", wb_c[6], 17);
    chk("R12", "mul2 writes", we_c[5], 1);
  endtask

  // Independent regs: FP f1, FP f5, ALU r2, FP f6 (third FP waits for a unit).
  task automatic t_contend();
    do_reset();
    @(posedge clk); #1 base = cyc;
    send(0, 2'd3, 1'b1, 4'd1,  4'd2,  4'd3);
    send(1, 2'd3, 1'b1, 4'd5,  4'd2,  4'd3);
    send(2, 2'd0, 1'b1, 4'd10, 4'd11, 4'd11);
    send(3, 2'd3, 1'b1, 4'd6,  4'd2,  4'd3);
    repeat (10) @(posedge clk);
    #1;
    chk("R10", "fpA tag", tg[0], 4); chk("R10", "fpB tag", tg[1], 5);
    chk("R11", "fpA is", is_c[0], 2); chk("R11", "fpB is", is_c[1], 3);
    chk("R11", "alu ds", ds_c[2], 3); chk("R11", "alu is", is_c[2], 4);
    chk("R9",  "alu wins wb", wb_c[2], 6);
    chk("R9",  "fpA wb after alu", wb_c[0], 7);
    chk("R9",  "fpB wb after fpA", wb_c[1], 8);
    chk("R3",  "fpD ds on freed FP", ds_c[3], 7);
    chk("R3",  "fpD tag", tg[3], 4);
    chk("R11", "fpD wb", wb_c[3], 12);
  endtask

  initial begin
    t_reset();
    t_loop();
    t_contend();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule